// File: doc/BRIEF.md
# Temperature Event Alert Logic

This block watches a stream of digital temperature samples and decides when to pull an active-low event line. Each sample is a 13-bit two's-complement reading in steps of 1/16 °C, qualified by a one-cycle valid strobe. Software programs an upper and a lower window limit, a critical limit and a release margin below the critical limit, a mode, and an enable bit. It can also clear a latched event through a write to the status location.

Three modes decide how a window violation drives the event line. Interrupt mode latches the violation until it is cleared. Comparator mode follows the latest sample. Critical-only mode ignores the window. The critical term always works like a comparator in every mode. It sets when a sample exceeds the critical limit and releases on its own once a sample falls below the critical limit minus the margin. The status output shows the pending event and the three condition flags from the latest sample.

Top module: `temp_event_alert`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `event_n` high, `status` 0, comparator mode, the event function disabled, the upper and critical limits at the most positive code, the lower limit at the most negative code and a zero margin.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. The addresses are 0 upper, 1 lower, 2 critical, 3 margin (bits 11:0, unsigned) and 4 control (bits 1:0 mode, where 0 is interrupt, 1 comparator, 2 critical-only and 3 comparator; bit 2 enable). Address 5 is the clear command. A written value applies to samples taken after the write edge.
- R3: The condition flags change only at an edge where `samp_valid` is high. Above means strictly greater than the upper limit and below means strictly less than the lower limit. A sample equal to a limit is not a violation.
- R4: In interrupt mode a violating sample sets a latch that drives the event. A later in-range sample does not release it. Only a clear with `wr_data[0]`=1 at address 5 releases it.
- R5: In comparator mode, and in mode code 3, the window term equals the above/below flags of the latest sample. It drops as soon as a sample lies inside the window.
- R6: In every mode, a sample greater than the critical limit asserts the critical term. The term then releases without any clear.
- R7: In critical-only mode the window flags have no effect on `event_n`, and a sample equal to the critical limit does not assert it.
- R8: The critical term stays set while samples lie between critical minus margin and the critical limit, including a sample exactly equal to critical minus margin. It releases on a sample strictly below critical minus margin.
- R9: A write to address 5 with `wr_data[0]`=0 changes nothing.
- R10: A clear while the violation persists re-asserts the latch on the next violating sample. When a violating sample and a clear arrive at the same edge, the latch stays set.
- R11: With the enable bit 0, `event_n` stays high and the pending bit stays 0, while the condition flags still update.
- R12: Every write to the control address releases the interrupt latch.
- R13: `status` is {critical, below, above, pending}, MSB first. `event_n` is the inverse of pending. Both are valid in the cycle after the edge that captured the sample or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Sample strobe |
| samp_temp | input | 13 | Signed temperature, 1/16 °C per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 13 | Register write data |
| event_n | output | 1 | Event line, active low |
| status | output | 4 | {critical, below, above, pending} |

## Verification
The bench builds the block with its default 13-bit temperature width. At this width, 1/16 °C readings from well below zero up to 255 °C are all in range, together with the extreme reset limits at both ends of the code space. The limits used in the tests (80, 0 and 95 °C with a 6 °C margin) place each comparison exactly on, one step above and one step below a boundary. They also let a sample exceed both the upper and the critical limit at once, which shows how the two terms interact in each mode.

// File: rtl/tea_pkg.sv
package tea_pkg;

    typedef enum logic [1:0] {
        MODE_INTR = 2'd0,
        MODE_COMP = 2'd1,
        MODE_CRIT = 2'd2,
        MODE_ALT  = 2'd3
    } evt_mode_e;

    localparam int          ADDR_W  = 3;
    localparam logic [2:0]  A_UPPER = 3'd0;
    localparam logic [2:0]  A_LOWER = 3'd1;
    localparam logic [2:0]  A_CRIT  = 3'd2;
    localparam logic [2:0]  A_HYST  = 3'd3;
    localparam logic [2:0]  A_CTRL  = 3'd4;
    localparam logic [2:0]  A_CLEAR = 3'd5;
    localparam int          EN_BIT  = 2;
    localparam int          CLR_BIT = 0;

    typedef struct packed {
        evt_mode_e mode;
        logic      en;
    } ctrl_t;

    typedef struct packed {
        logic crit;
        logic below;
        logic above;
    } flags_t;

    function automatic logic win_counts(evt_mode_e m);
        return (m != MODE_CRIT);
    endfunction

endpackage

// File: rtl/tea_regs.sv
module tea_regs
    import tea_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [TW-1:0]        wr_data,
    output logic [TW-1:0]        lim_upper,
    output logic [TW-1:0]        lim_lower,
    output logic [TW-1:0]        lim_crit,
    output logic [TW-2:0]        lim_hyst,
    output ctrl_t                ctrl,
    output logic                 ctrl_wr,
    output logic                 clr_pulse
);
    localparam logic [TW-1:0] T_MAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] T_MIN = {1'b1, {(TW-1){1'b0}}};

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign clr_pulse = wr_en && (wr_addr == A_CLEAR) && wr_data[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_upper <= T_MAX;
            lim_lower <= T_MIN;
            lim_crit  <= T_MAX;
            lim_hyst  <= '0;
            ctrl.mode <= MODE_COMP;
            ctrl.en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_UPPER: lim_upper <= wr_data;
                A_LOWER: lim_lower <= wr_data;
                A_CRIT:  lim_crit  <= wr_data;
                A_HYST:  lim_hyst  <= wr_data[TW-2:0];
                A_CTRL: begin
                    ctrl.mode <= evt_mode_e'(wr_data[1:0]);
                    ctrl.en   <= wr_data[EN_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tea_cmp.sv
module tea_cmp
    import tea_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           samp_valid,
    input  logic [TW-1:0]  samp_temp,
    input  logic [TW-1:0]  lim_upper,
    input  logic [TW-1:0]  lim_lower,
    input  logic [TW-1:0]  lim_crit,
    input  logic [TW-2:0]  lim_hyst,
    output flags_t         flags,
    output logic           win_hit
);
    localparam int XW = TW + 1;

    logic signed [XW-1:0] t_x, up_x, lo_x, cr_x, rel_x;

    assign t_x   = $signed({samp_temp[TW-1], samp_temp});
    assign up_x  = $signed({lim_upper[TW-1], lim_upper});
    assign lo_x  = $signed({lim_lower[TW-1], lim_lower});
    assign cr_x  = $signed({lim_crit[TW-1],  lim_crit});
    assign rel_x = cr_x - $signed({2'b00, lim_hyst});

    assign win_hit = samp_valid && ((t_x > up_x) || (t_x < lo_x));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (samp_valid) begin
            flags.above <= (t_x > up_x);
            flags.below <= (t_x < lo_x);
            if (t_x > cr_x)
                flags.crit <= 1'b1;
            else if (t_x < rel_x)
                flags.crit <= 1'b0;
        end
    end

    p_flags_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |=> $stable(flags));
    p_crit_set_r6: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && (t_x > cr_x)) |=> flags.crit);
    p_crit_release_r8: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && (t_x < rel_x)) |=> !flags.crit);

endmodule

// File: rtl/tea_evt.sv
module tea_evt
    import tea_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctrl,
    input  logic    ctrl_wr,
    input  logic    clr_pulse,
    input  logic    win_hit,
    input  flags_t  flags,
    output logic    pending,
    output logic    event_n
);
    logic latch_q;
    logic win_term;
    logic active;

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else if (win_hit && ctrl.en && (ctrl.mode == MODE_INTR))
            latch_q <= 1'b1;
        else if (clr_pulse || ctrl_wr)
            latch_q <= 1'b0;
    end

    always_comb begin
        if (ctrl.mode == MODE_INTR)
            win_term = latch_q;
        else if (win_counts(ctrl.mode))
            win_term = flags.above | flags.below;
        else
            win_term = 1'b0;
        active  = win_term | flags.crit;
        pending = ctrl.en & active;
        event_n = ~pending;
    end

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr_pulse && !ctrl_wr) |=> latch_q);
    p_clear_releases_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !win_hit) |=> !latch_q);
    p_ctrl_releases_r12: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !win_hit) |=> !latch_q);

endmodule

// File: rtl/temp_event_alert.sv
module temp_event_alert
    import tea_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               samp_valid,
    input  logic [TW-1:0]      samp_temp,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [TW-1:0]      wr_data,
    output logic               event_n,
    output logic [3:0]         status
);
    logic [TW-1:0] lim_upper, lim_lower, lim_crit;
    logic [TW-2:0] lim_hyst;
    ctrl_t         ctrl;
    logic          ctrl_wr, clr_pulse, win_hit, pending;
    flags_t        flags;

    tea_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lim_upper(lim_upper), .lim_lower(lim_lower), .lim_crit(lim_crit),
        .lim_hyst(lim_hyst), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .clr_pulse(clr_pulse)
    );

    tea_cmp #(.TW(TW)) u_cmp (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_temp(samp_temp),
        .lim_upper(lim_upper), .lim_lower(lim_lower), .lim_crit(lim_crit),
        .lim_hyst(lim_hyst), .flags(flags), .win_hit(win_hit)
    );

    tea_evt u_evt (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .clr_pulse(clr_pulse),
        .win_hit(win_hit), .flags(flags), .pending(pending), .event_n(event_n)
    );

    assign status = {flags.crit, flags.below, flags.above, pending};

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == A_CLEAR) && !wr_data[CLR_BIT] && !samp_valid)
            |=> ($stable(event_n) && $stable(status)));
    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ctrl.en) |=> event_n);

endmodule

// File: tb/temp_event_alert_test.sv
module temp_event_alert_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              samp_valid = 1'b0;
    logic [12:0]       samp_temp = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [12:0]       wr_data = '0;
    logic              event_n;
    logic [3:0]        status;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    temp_event_alert uut (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_temp(samp_temp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .event_n(event_n), .status(status)
    );

    // behavioural reference model
    int m_up, m_lo, m_cr, m_hy, m_mode, t;
    bit m_en, m_lat, m_ab, m_be, m_cs, hit, int_arm, act, pend;

    always @(posedge clk) begin
        if (rst) begin
            m_up = 4095; m_lo = -4096; m_cr = 4095; m_hy = 0;
            m_mode = 1; m_en = 0; m_lat = 0; m_ab = 0; m_be = 0; m_cs = 0;
        end else begin
            hit = 0;
            int_arm = (m_mode == 0) && m_en;
            if (samp_valid) begin
                t = int'($signed(samp_temp));
                m_ab = t > m_up;
                m_be = t < m_lo;
                hit = m_ab || m_be;
                if (t > m_cr) m_cs = 1;
                else if (t < m_cr - m_hy) m_cs = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_up = int'($signed(wr_data));
                    3'd1: m_lo = int'($signed(wr_data));
                    3'd2: m_cr = int'($signed(wr_data));
                    3'd3: m_hy = int'(wr_data[11:0]);
                    3'd4: begin m_mode = int'(wr_data[1:0]); m_en = wr_data[2]; m_lat = 0; end
                    3'd5: if (wr_data[0]) m_lat = 0;
                    default: ;
                endcase
            end
            if (hit && int_arm) m_lat = 1;
        end
        act  = ((m_mode == 0) ? m_lat : (m_mode == 2) ? 1'b0 : (m_ab | m_be)) | m_cs;
        pend = m_en && act;
        #2;
        vectors++;
        if ({event_n, status} !== {~pend, m_cs, m_be, m_ab, pend}) begin
            fails++;
            $display("FAIL %s model: event_n=%b status=%b expected event_n=%b status=%b",
                     cur_req, event_n, status, ~pend, {m_cs, m_be, m_ab, pend});
        end
    end

    task automatic chk(input string req, input logic exp_ev, input logic [3:0] exp_st);
        vectors++;
        if (event_n !== exp_ev || status !== exp_st) begin
            fails++;
            $display("FAIL %s: event_n=%b status=%b expected event_n=%b status=%b",
                     req, event_n, status, exp_ev, exp_st);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = 13'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic samp(input int v);
        @(negedge clk); samp_valid = 1'b1; samp_temp = 13'(v);
        @(negedge clk); samp_valid = 1'b0;
    endtask

    task automatic samp_wr(input int v, input logic [2:0] a, input int d);
        @(negedge clk); samp_valid = 1'b1; samp_temp = 13'(v);
        wr_en = 1'b1; wr_addr = a; wr_data = 13'(d);
        @(negedge clk); samp_valid = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", 1'b1, 4'b0000);
        samp(4095);  chk("R1", 1'b1, 4'b0000);
        samp(-4096); chk("R1", 1'b1, 4'b0000);

        cur_req = "R2";
        wreg(3'd0, 1280); wreg(3'd1, 0); wreg(3'd2, 1520); wreg(3'd3, 96);
        wreg(3'd4, 5);
        cur_req = "R5";
        samp(480);  chk("R5", 1'b1, 4'b0000);
        samp(1300); chk("R5", 1'b0, 4'b0011);
        cur_req = "R3";
        samp(1280); chk("R3", 1'b1, 4'b0000);
        samp(-16);  chk("R3", 1'b0, 4'b0101);
        @(negedge clk); samp_temp = 13'(1300);
        repeat (3) @(negedge clk);
        chk("R3", 1'b0, 4'b0101);
        cur_req = "R5";
        samp(480);  chk("R5", 1'b1, 4'b0000);

        cur_req = "R4";
        wreg(3'd4, 4);
        samp(1300); chk("R4", 1'b0, 4'b0011);
        samp(480);  chk("R4", 1'b0, 4'b0001);
        cur_req = "R9";
        wreg(3'd5, 2); chk("R9", 1'b0, 4'b0001);
        cur_req = "R4";
        wreg(3'd5, 1); chk("R4", 1'b1, 4'b0000);
        cur_req = "R10";
        samp(1300); chk("R10", 1'b0, 4'b0011);
        wreg(3'd5, 1); chk("R10", 1'b1, 4'b0010);
        samp(1300); chk("R10", 1'b0, 4'b0011);
        samp_wr(1300, 3'd5, 1); chk("R10", 1'b0, 4'b0011);
        cur_req = "R4";
        samp_wr(480, 3'd5, 1); chk("R4", 1'b1, 4'b0000);
        cur_req = "R12";
        samp(1300); chk("R12", 1'b0, 4'b0011);
        wreg(3'd4, 4); chk("R12", 1'b1, 4'b0010);

        cur_req = "R6";
        wreg(3'd0, 2000);
        samp(1600); chk("R6", 1'b0, 4'b1001);
        samp(1500); chk("R6", 1'b0, 4'b1001);
        samp(1423); chk("R6", 1'b1, 4'b0000);

        cur_req = "R7";
        wreg(3'd0, 1280); wreg(3'd4, 6);
        samp(1300); chk("R7", 1'b1, 4'b0010);
        samp(-100); chk("R7", 1'b1, 4'b0100);
        samp(1521); chk("R7", 1'b0, 4'b1011);
        cur_req = "R8";
        samp(1500); chk("R8", 1'b0, 4'b1011);
        samp(1424); chk("R8", 1'b0, 4'b1011);
        samp(1423); chk("R8", 1'b1, 4'b0010);
        cur_req = "R7";
        samp(1520); chk("R7", 1'b1, 4'b0010);

        cur_req = "R11";
        wreg(3'd4, 1);
        samp(1600); chk("R11", 1'b1, 4'b1010);
        cur_req = "R13";
        wreg(3'd4, 5); chk("R13", 1'b0, 4'b1011);
        samp(480);     chk("R13", 1'b1, 4'b0000);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule